// File: doc/BRIEF.md
# Flash Block Lock-Bit Protection Controller

This block is the command sequencer and write-protect logic placed in front of a block-lockable flash array. Software writes lock commands as two bus writes: a setup code followed by a confirm code. The confirm code selects one of three operations: set the lock-bit of one block, set the single master lock-bit, or clear every block lock-bit at once. The block checks each confirmed operation against the master lock-bit, the reset-pin level, the program-enable supply and the suspend state. It either starts the operation and holds busy for a fixed number of cycles, or refuses it and records the cause as a pair of status bits.

The same protection state also gates block erase and program requests. A request aimed at a locked block is refused unless the reset pin sits at its elevated override level. The elevated level also overrides the master lock-bit for changes to block lock-bits. The master lock-bit can only ever be set. The cell array, the voltage sensing (given here as digital level flags) and the real erase and program algorithms are outside the block. A fixed busy time stands in for each of them.

Top module: `flp_lock_ctrl`

## Requirements
- R1: After reset all block lock-bits and the master lock-bit are 0, the status byte is 0x80, ready is 1 and reads return array data (rd_status_mode = 0).
- R2: A setup write (0x60) followed by a confirm 0x01 sets the lock-bit of the block on wr_blk when the master lock-bit is 0. Ready is low for exactly LOCK_CYCLES cycles after the confirm edge, and the lock-bit changes at the edge that ends busy.
- R3: With the master lock-bit set, a block lock-bit set at normal reset level fails: status bits 1 and 4 go to 1 and no lock-bit changes. At the elevated level (rp_elev = 1) it succeeds.
- R4: Setting the master lock-bit (confirm 0xF1) needs rp_elev = 1. Without it, status bits 1 and 4 go to 1 and the master lock-bit stays 0.
- R5: Confirm 0xD0 clears all block lock-bits in one operation. With the master lock-bit set and rp_elev = 0 it fails instead: status bits 1 and 5 go to 1 and the lock-bits are kept.
- R6: A confirm write with any code other than 0x01, 0xF1 or 0xD0 sets status bits 4 and 5, changes no lock-bit and does not go busy.
- R7: If vpen_ok is 0 at a confirm, status bit 3 is set along with bit 5 (clear) or bit 4 (block or master set), and the lock state is unchanged.
- R8: After a setup write, rd_status_mode is 1 and stays 1 until a 0xFF write returns reads to array data.
- R9: All writes are ignored while busy. A clear confirm while suspended = 1 is refused with status bits 4 and 5 and no lock change.
- R10: No command ever clears the master lock-bit. A successful clear of all lock-bits leaves it at 1.
- R11: An erase (op_erase = 1) or program request on a locked block with rp_elev = 0 does not start. It sets status bit 1 plus bit 5 (erase) or bit 4 (program). Otherwise op_start pulses for one cycle and ready is low for OP_CYCLES cycles.
- R12: Error bits 5, 4, 3 and 1 are sticky across later operations, and only a 0x50 write (when not busy and not in setup) clears them. Status bit 7 equals ready, and bits 6, 2 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 8 | Command code |
| wr_blk | input | BLK_W | Target block for a block lock-bit set |
| op_req | input | 1 | Erase or program request strobe |
| op_erase | input | 1 | 1 = erase, 0 = program |
| op_blk | input | BLK_W | Target block of the erase or program request |
| rp_elev | input | 1 | Reset pin at elevated override level |
| vpen_ok | input | 1 | Program-enable supply within valid range |
| suspended | input | 1 | An erase or program is currently suspended |
| ready | output | 1 | 1 = idle, 0 = busy |
| status | output | 8 | Status byte |
| rd_status_mode | output | 1 | Reads return status instead of array data |
| lock_bits | output | NBLK | Per-block lock-bits |
| master_lock | output | 1 | Master lock-bit |
| op_start | output | 1 | One-cycle pulse when an erase or program begins |

## Verification
Each lock confirm code is driven under every combination that matters: master lock-bit clear or set, reset pin normal or elevated, supply valid or not, and suspend active or not. The aim is to show which of these conditions decides success, and which status-bit pair each failure cause raises. Illegal confirm codes, and writes during busy, separate a rejected sequence from an accepted one by the absence of a busy period. Erase and program requests go to locked and unlocked blocks at both reset levels, which shows the block-lock override apart from the ordinary unlocked path. The clear-status write is issued only after later successful operations, so the test shows that error bits persist.

// File: rtl/flp_pkg.sv
package flp_pkg;
    localparam logic [7:0] CMD_SETUP   = 8'h60;
    localparam logic [7:0] CMD_SET_BLK = 8'h01;
    localparam logic [7:0] CMD_SET_MST = 8'hF1;
    localparam logic [7:0] CMD_CLR_ALL = 8'hD0;
    localparam logic [7:0] CMD_CLR_SR  = 8'h50;
    localparam logic [7:0] CMD_ARRAY   = 8'hFF;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_SET_BLK,
        ACT_SET_MST,
        ACT_CLR_ALL
    } act_e;

    typedef enum logic [1:0] {
        MODE_ARRAY,
        MODE_STATUS,
        MODE_SETUP
    } mode_e;

    typedef struct packed {
        logic clr;   // status bit 5
        logic set;   // status bit 4
        logic sup;   // status bit 3
        logic prot;  // status bit 1
    } err_t;
endpackage

// File: rtl/flp_cmd_eval.sv
module flp_cmd_eval
    import flp_pkg::*;
(
    input  logic [7:0] code,
    input  logic       master,
    input  logic       rp_elev,
    input  logic       vpen_ok,
    input  logic       suspended,
    output act_e       act,
    output err_t       err
);
    always_comb begin
        act = ACT_NONE;
        err = '0;
        case (code)
            CMD_SET_BLK: begin
                if (!vpen_ok) begin
                    err.sup = 1'b1;
                    err.set = 1'b1;
                end else if (master && !rp_elev) begin
                    err.prot = 1'b1;
                    err.set  = 1'b1;
                end else begin
                    act = ACT_SET_BLK;
                end
            end
            CMD_SET_MST: begin
                if (!vpen_ok) begin
                    err.sup = 1'b1;
                    err.set = 1'b1;
                end else if (!rp_elev) begin
                    err.prot = 1'b1;
                    err.set  = 1'b1;
                end else begin
                    act = ACT_SET_MST;
                end
            end
            CMD_CLR_ALL: begin
                if (suspended) begin
                    err.set = 1'b1;
                    err.clr = 1'b1;
                end else if (!vpen_ok) begin
                    err.sup = 1'b1;
                    err.clr = 1'b1;
                end else if (master && !rp_elev) begin
                    err.prot = 1'b1;
                    err.clr  = 1'b1;
                end else begin
                    act = ACT_CLR_ALL;
                end
            end
            default: begin
                err.set = 1'b1;
                err.clr = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/flp_protect_gate.sv
module flp_protect_gate
    import flp_pkg::*;
#(
    parameter int NBLK  = 8,
    localparam int BLK_W = $clog2(NBLK)
) (
    input  logic [NBLK-1:0]  lock_bits,
    input  logic [BLK_W-1:0] blk,
    input  logic             is_erase,
    input  logic             rp_elev,
    output logic             allow,
    output err_t             err
);
    logic locked;

    always_comb begin
        locked = 1'b1;
        if (int'(blk) < NBLK) locked = lock_bits[blk];
        allow = !locked || rp_elev;
        err = '0;
        if (!allow) begin
            err.prot = 1'b1;
            err.clr  = is_erase;
            err.set  = !is_erase;
        end
    end
endmodule

// File: rtl/flp_busy_timer.sv
module flp_busy_timer #(
    parameter int LOCK_CYCLES = 6,
    parameter int OP_CYCLES   = 4,
    localparam int MAXC = (LOCK_CYCLES > OP_CYCLES) ? LOCK_CYCLES : OP_CYCLES,
    localparam int CW   = $clog2(MAXC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_sel,
    output logic busy,
    output logic done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = long_sel ? CW'(LOCK_CYCLES) : CW'(OP_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/flp_lock_ctrl.sv
module flp_lock_ctrl
    import flp_pkg::*;
#(
    parameter int NBLK        = 8,
    parameter int LOCK_CYCLES = 6,
    parameter int OP_CYCLES   = 4,
    localparam int BLK_W      = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [BLK_W-1:0] wr_blk,
    input  logic             op_req,
    input  logic             op_erase,
    input  logic [BLK_W-1:0] op_blk,
    input  logic             rp_elev,
    input  logic             vpen_ok,
    input  logic             suspended,
    output logic             ready,
    output logic [7:0]       status,
    output logic             rd_status_mode,
    output logic [NBLK-1:0]  lock_bits,
    output logic             master_lock,
    output logic             op_start
);
    typedef struct packed {
        mode_e            mode;
        logic [NBLK-1:0]  locks;
        logic             master;
        act_e             pend_act;
        logic [BLK_W-1:0] pend_blk;
        err_t             err;
        logic             op_start;
    } state_t;

    state_t st_d, st_q;

    act_e eval_act;
    err_t eval_err;
    logic gate_allow;
    err_t gate_err;
    logic tmr_start, tmr_long, tmr_busy, tmr_done;

    flp_cmd_eval u_eval (
        .code      (wr_data),
        .master    (st_q.master),
        .rp_elev   (rp_elev),
        .vpen_ok   (vpen_ok),
        .suspended (suspended),
        .act       (eval_act),
        .err       (eval_err)
    );

    flp_protect_gate #(.NBLK(NBLK)) u_gate (
        .lock_bits (st_q.locks),
        .blk       (op_blk),
        .is_erase  (op_erase),
        .rp_elev   (rp_elev),
        .allow     (gate_allow),
        .err       (gate_err)
    );

    flp_busy_timer #(.LOCK_CYCLES(LOCK_CYCLES), .OP_CYCLES(OP_CYCLES)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tmr_start),
        .long_sel (tmr_long),
        .busy     (tmr_busy),
        .done     (tmr_done)
    );

    always_comb begin
        st_d          = st_q;
        st_d.op_start = 1'b0;
        tmr_start     = 1'b0;
        tmr_long      = 1'b0;

        // Completion of a lock operation commits the pending change.
        if (tmr_done) begin
            case (st_q.pend_act)
                ACT_SET_BLK: st_d.locks[st_q.pend_blk] = 1'b1;
                ACT_SET_MST: st_d.master = 1'b1;
                ACT_CLR_ALL: st_d.locks = '0;
                default: ;
            endcase
            st_d.pend_act = ACT_NONE;
        end

        if (!tmr_busy) begin
            if (wr_en) begin
                if (st_q.mode == MODE_SETUP) begin
                    st_d.mode = MODE_STATUS;
                    st_d.err  = st_q.err | eval_err;
                    if (eval_act != ACT_NONE) begin
                        tmr_start     = 1'b1;
                        tmr_long      = 1'b1;
                        st_d.pend_act = eval_act;
                        st_d.pend_blk = wr_blk;
                    end
                end else begin
                    case (wr_data)
                        CMD_SETUP:  st_d.mode = MODE_SETUP;
                        CMD_CLR_SR: st_d.err  = '0;
                        CMD_ARRAY:  st_d.mode = MODE_ARRAY;
                        default: ;
                    endcase
                end
            end else if (op_req && st_q.mode != MODE_SETUP) begin
                st_d.mode = MODE_STATUS;
                if (gate_allow) begin
                    tmr_start     = 1'b1;
                    st_d.op_start = 1'b1;
                end else begin
                    st_d.err = st_q.err | gate_err;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode     <= MODE_ARRAY;
            st_q.locks    <= '0;
            st_q.master   <= 1'b0;
            st_q.pend_act <= ACT_NONE;
            st_q.pend_blk <= '0;
            st_q.err      <= '0;
            st_q.op_start <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready          = !tmr_busy;
    assign status         = {!tmr_busy, 1'b0, st_q.err.clr, st_q.err.set,
                             st_q.err.sup, 1'b0, st_q.err.prot, 1'b0};
    assign rd_status_mode = (st_q.mode != MODE_ARRAY);
    assign lock_bits      = st_q.locks;
    assign master_lock    = st_q.master;
    assign op_start       = st_q.op_start;
endmodule

// File: rtl/flp_lock_ctrl_chk.sv
module flp_lock_ctrl_chk #(
    parameter int NBLK     = 8,
    localparam int BLK_W   = $clog2(NBLK)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready,
    input logic [7:0]       status,
    input logic [NBLK-1:0]  lock_bits,
    input logic             master_lock,
    input logic             op_start,
    input logic [BLK_W-1:0] op_blk,
    input logic             rp_elev,
    input logic             vpen_ok
);
    AST_MASTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(master_lock) |-> master_lock); // R10

    AST_LOCK_CHANGE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_bits) |-> (ready && !$past(ready))); // R2

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> ($stable(lock_bits) && $stable(master_lock))); // R9

    AST_OP_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> !ready); // R11

    AST_LOCKED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> ($past(rp_elev) || !$past(lock_bits[op_blk]))); // R11

    AST_SUPPLY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[3]) |-> !$past(vpen_ok)); // R7
endmodule

bind flp_lock_ctrl flp_lock_ctrl_chk #(.NBLK(NBLK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready       (ready),
    .status      (status),
    .lock_bits   (lock_bits),
    .master_lock (master_lock),
    .op_start    (op_start),
    .op_blk      (op_blk),
    .rp_elev     (rp_elev),
    .vpen_ok     (vpen_ok)
);

// File: tb/flp_lock_ctrl_tb.sv
module flp_lock_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NBLK  = 8;
    localparam int LOCKC = 6;
    localparam int OPC   = 4;
    localparam int BLK_W = $clog2(NBLK);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [BLK_W-1:0] wr_blk = '0;
    logic op_req = 1'b0;
    logic op_erase = 1'b0;
    logic [BLK_W-1:0] op_blk = '0;
    logic rp_elev = 1'b0;
    logic vpen_ok = 1'b1;
    logic suspended = 1'b0;
    logic ready;
    logic [7:0] status;
    logic rd_status_mode;
    logic [NBLK-1:0] lock_bits;
    logic master_lock;
    logic op_start;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flp_lock_ctrl #(.NBLK(NBLK), .LOCK_CYCLES(LOCKC), .OP_CYCLES(OPC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_blk(wr_blk),
        .op_req(op_req), .op_erase(op_erase), .op_blk(op_blk), .rp_elev(rp_elev),
        .vpen_ok(vpen_ok), .suspended(suspended), .ready(ready), .status(status),
        .rd_status_mode(rd_status_mode), .lock_bits(lock_bits),
        .master_lock(master_lock), .op_start(op_start)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d, input int b = 0);
        wr_en = 1'b1; wr_data = d; wr_blk = BLK_W'(b);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rdy(output int n);
        n = 0;
        while (!ready && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic lock_op(input logic [7:0] code, input int b, output int n);
        wr(8'h60);
        wr(code, b);
        wait_rdy(n);
    endtask

    task automatic do_op(input bit erase, input int b);
        op_req = 1'b1; op_erase = erase; op_blk = BLK_W'(b);
        @(negedge clk);
        op_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 status", status, 32'h80);
        chk("R1 locks", lock_bits, 0);
        chk("R1 master", master_lock, 0);
        chk("R1 ready", ready, 1);
        chk("R1 mode", rd_status_mode, 0);
    endtask

    task automatic t_block_set();
        int n;
        lock_op(8'h01, 3, n);
        chk("R2 busy cycles", n, LOCKC);
        chk("R2 locks", lock_bits, 32'h08);
        chk("R2 status", status, 32'h80);
        chk("R8 status mode after setup", rd_status_mode, 1);
        lock_op(8'h01, 5, n);
        chk("R2 second lock", lock_bits, 32'h28);
    endtask

    task automatic t_mode_and_bad();
        int n;
        wr(8'hFF);
        chk("R8 array mode", rd_status_mode, 0);
        wr(8'h60);
        chk("R8 setup mode", rd_status_mode, 1);
        wr(8'h33);
        chk("R6 bad confirm status", status, 32'hB0);
        chk("R6 no busy", ready, 1);
        chk("R6 locks kept", lock_bits, 32'h28);
        lock_op(8'h01, 0, n);
        chk("R12 sticky after success", status, 32'hB0);
        chk("R12 lock done", lock_bits, 32'h29);
        wr(8'h50);
        chk("R12 clear status", status, 32'h80);
    endtask

    task automatic t_supply();
        vpen_ok = 1'b0;
        wr(8'h60); wr(8'hD0);
        chk("R7 clear w/o supply", status, 32'hA8);
        chk("R7 locks kept", lock_bits, 32'h29);
        wr(8'h50);
        wr(8'h60); wr(8'h01, 6);
        chk("R7 set w/o supply", status, 32'h98);
        chk("R7 locks kept set", lock_bits, 32'h29);
        wr(8'h50);
        vpen_ok = 1'b1;
    endtask

    task automatic t_busy();
        int n;
        wr(8'h60); wr(8'h77);
        wr(8'h60); wr(8'h01, 2);
        chk("R9 busy", ready, 0);
        wr(8'h50);
        wait_rdy(n);
        chk("R9 write ignored while busy", status, 32'hB0);
        chk("R9 lock done", lock_bits, 32'h2D);
        wr(8'h50);
        suspended = 1'b1;
        wr(8'h60); wr(8'hD0);
        chk("R9 suspended clear refused", status, 32'hB0);
        chk("R9 locks kept", lock_bits, 32'h2D);
        suspended = 1'b0;
        wr(8'h50);
    endtask

    task automatic t_gate();
        int n;
        do_op(1'b1, 2);
        chk("R11 erase locked no start", op_start, 0);
        chk("R11 erase locked status", status, 32'hA2);
        wr(8'h50);
        do_op(1'b0, 2);
        chk("R11 program locked status", status, 32'h92);
        wr(8'h50);
        do_op(1'b1, 6);
        chk("R11 unlocked start", op_start, 1);
        wait_rdy(n);
        chk("R11 op busy cycles", n, OPC);
        rp_elev = 1'b1;
        do_op(1'b0, 2);
        chk("R11 override start", op_start, 1);
        chk("R11 override status", status, 32'h00);
        wait_rdy(n);
        rp_elev = 1'b0;
    endtask

    task automatic t_clear_free();
        int n;
        lock_op(8'hD0, 0, n);
        chk("R5 clear all", lock_bits, 0);
        chk("R5 clear busy", n, LOCKC);
        lock_op(8'h01, 4, n);
    endtask

    task automatic t_master();
        int n;
        lock_op(8'hF1, 0, n);
        chk("R4 master normal status", status, 32'h92);
        chk("R4 master normal bit", master_lock, 0);
        wr(8'h50);
        rp_elev = 1'b1;
        lock_op(8'hF1, 0, n);
        rp_elev = 1'b0;
        chk("R4 master elevated", master_lock, 1);
        chk("R4 master busy", n, LOCKC);
    endtask

    task automatic t_master_gate();
        int n;
        lock_op(8'h01, 7, n);
        chk("R3 set refused status", status, 32'h92);
        chk("R3 set refused locks", lock_bits, 32'h10);
        wr(8'h50);
        rp_elev = 1'b1;
        lock_op(8'h01, 7, n);
        rp_elev = 1'b0;
        chk("R3 set override", lock_bits, 32'h90);
        lock_op(8'hD0, 0, n);
        chk("R5 clear refused status", status, 32'hA2);
        chk("R5 clear refused locks", lock_bits, 32'h90);
        wr(8'h50);
        rp_elev = 1'b1;
        lock_op(8'hD0, 0, n);
        rp_elev = 1'b0;
        chk("R5 clear override", lock_bits, 0);
        chk("R10 master kept", master_lock, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_block_set();
        t_mode_and_bad();
        t_supply();
        t_busy();
        t_gate();
        t_clear_free();
        t_master();
        t_master_gate();
        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule